// File: doc/BRIEF.md
# StreamID Span-Match Event Filter

This block decides, for every counter in a performance-monitor counter group, whether an incoming translation event should be counted. Each event arrives with a valid strobe and a StreamID. Each counter holds a 32-bit match value and a span bit. The block compares the event StreamID against the match value, either for exact equality or under a wildcard mask. In span mode that mask is derived from the match value itself: the lowest zero bit of the value, and every bit beneath it, become don't-care.

Software turns filtering off by programming an all-ones match value with span set, which makes every StreamID qualify. A global-mode input makes counter 0's match value and span bit govern all counters. Without it, each counter filters on its own settings.

Only the low `SID_BITS` StreamID bits are implemented. The result is a per-counter qualify vector, registered one clock after the event strobe. The event classification and the counters themselves are outside this block.

Top module: `sid_span_filter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `qualify_o` is all zeros.
- R2: `qualify_o` is due one clock after the edge that samples `evt_valid_i` high, and it reflects that event. After an edge where `evt_valid_i` is low, `qualify_o` is all zeros whatever the StreamID and match values are.
- R3: With span bit 0 (exact mode), counter k qualifies only when the low `SID_BITS` of the StreamID equal the low `SID_BITS` of its match value.
- R4: With span bit 1, let Y-1 be the position of the lowest zero bit of the match value. Bits Y-1..0 are ignored and bits from Y upward must be equal. Match 0x42 qualifies StreamIDs 0x42 and 0x43 but not 0x40 or 0x44.
- R5: Span mode widens with longer runs of low ones. Match 0x1237 qualifies every StreamID from 0x1230 to 0x123F and nothing outside that range.
- R6: With span bit 1 and the low `SID_BITS` of the match value all ones, every StreamID qualifies (filter bypass).
- R7: StreamID bits and match-value bits at or above `SID_BITS` never affect the result, in either mode.
- R8: With `global_mode_i` low, each counter uses only its own match value and span bit, so counters with different settings give different results for the same event.
- R9: With `global_mode_i` high, every counter uses counter 0's match value and span bit, and the other counters' settings have no effect.
- R10: The match values, span bits and global mode are sampled on the same edge as the event strobe. A change made after that edge does not alter the result for that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid_i | input | 1 | Event strobe, one event per cycle |
| evt_sid_i | input | 32 | StreamID of the event |
| match_i | input | NUM_CTR*32 | Per-counter match values; counter k occupies bits 32k+31..32k |
| span_i | input | NUM_CTR | Per-counter span bit (1 = span match, 0 = exact) |
| global_mode_i | input | 1 | 1 = counter 0's filter settings apply to every counter |
| qualify_o | output | NUM_CTR | Registered per-counter qualify vector |

## Verification
Every result is due exactly one clock after the edge that samples the strobe, because the only register in the path is the qualify register. The bench drives inputs on the falling edge and holds the strobe high for one rising edge. It reads `qualify_o` on the next falling edge, the first point after the result register has loaded. To check the sampling point, the bench changes a match value just after the capturing edge and confirms that the result still reflects the old value. It then confirms that the output falls back to zero one cycle later.

// File: rtl/sidf_pkg.sv
package sidf_pkg;
  localparam int MATCH_W = 32;

  typedef struct packed {
    logic [MATCH_W-1:0] match;
    logic               span;
  } filt_cfg_t;
endpackage

// File: rtl/sidf_cfg_select.sv
module sidf_cfg_select
  import sidf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic [NUM_CTR*MATCH_W-1:0]  match_i,
  input  logic [NUM_CTR-1:0]          span_i,
  input  logic                        global_mode_i,
  output filt_cfg_t [NUM_CTR-1:0]     cfg_o
);
  // Counter 0 always uses its own settings; the others follow it in global mode.
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
    localparam int SRC_LO = k * MATCH_W;
    if (k == 0) begin : g_leader
      assign cfg_o[k].match = match_i[MATCH_W-1:0];
      assign cfg_o[k].span  = span_i[0];
    end else begin : g_follower
      assign cfg_o[k].match = global_mode_i ? match_i[MATCH_W-1:0]
                                            : match_i[SRC_LO +: MATCH_W];
      assign cfg_o[k].span  = global_mode_i ? span_i[0] : span_i[k];
    end
  end
endmodule

// File: rtl/sidf_wildcard.sv
module sidf_wildcard
  import sidf_pkg::*;
#(
  parameter int SID_BITS = 16
) (
  input  filt_cfg_t             cfg_i,
  output logic [SID_BITS-1:0]   care_o
);
  logic [SID_BITS-1:0] m_lo;
  logic [SID_BITS-1:0] m_inc;
  logic [SID_BITS-1:0] dont_care;

  assign m_lo  = cfg_i.match[SID_BITS-1:0];
  // The increment flips the trailing ones and the lowest zero; XOR marks them.
  assign m_inc = m_lo + SID_BITS'(1);
  assign dont_care = cfg_i.span ? (m_lo ^ m_inc) : '0;
  assign care_o = ~dont_care;
endmodule

// File: rtl/sidf_compare.sv
module sidf_compare #(
  parameter int SID_BITS = 16
) (
  input  logic [SID_BITS-1:0] sid_i,
  input  logic [SID_BITS-1:0] match_i,
  input  logic [SID_BITS-1:0] care_i,
  output logic                hit_o
);
  logic [SID_BITS-1:0] diff;

  assign diff  = (sid_i ^ match_i) & care_i;
  assign hit_o = ~|diff;
endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
  import sidf_pkg::*;
#(
  parameter int NUM_CTR  = 4,
  parameter int SID_BITS = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       evt_valid_i,
  input  logic [31:0]                evt_sid_i,
  input  logic [NUM_CTR*32-1:0]      match_i,
  input  logic [NUM_CTR-1:0]         span_i,
  input  logic                       global_mode_i,
  output logic [NUM_CTR-1:0]         qualify_o
);
  localparam int SB = (SID_BITS > MATCH_W) ? MATCH_W : SID_BITS;

  filt_cfg_t [NUM_CTR-1:0]  cfg;
  logic [SB-1:0]            care [NUM_CTR];
  logic [NUM_CTR-1:0]       hit;
  logic [SB-1:0]            sid_lo;

  assign sid_lo = evt_sid_i[SB-1:0];

  sidf_cfg_select #(.NUM_CTR(NUM_CTR)) cfg_sel_i (
    .match_i       (match_i),
    .span_i        (span_i),
    .global_mode_i (global_mode_i),
    .cfg_o         (cfg)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    sidf_wildcard #(.SID_BITS(SB)) wc_i (
      .cfg_i  (cfg[k]),
      .care_o (care[k])
    );

    sidf_compare #(.SID_BITS(SB)) cmp_i (
      .sid_i   (sid_lo),
      .match_i (cfg[k].match[SB-1:0]),
      .care_i  (care[k]),
      .hit_o   (hit[k])
    );

    // R4
    span_low_dc_chk: assert property (@(posedge clk) disable iff (rst)
      cfg[k].span |-> !care[k][0]);

    // R4
    span_contig_chk: assert property (@(posedge clk) disable iff (rst)
      ((~care[k]) & ((~care[k]) + SB'(1))) == '0);

    // R3
    exact_full_care_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg[k].span |-> (&care[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qualify_o <= '0;
    end else if (evt_valid_i) begin
      qualify_o <= hit;
    end else begin
      qualify_o <= '0;
    end
  end

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_valid_i |=> (qualify_o == '0));

  // R9
  global_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_i && global_mode_i) |=> (qualify_o == '0 || qualify_o == '1));

  // R3
  exact_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_i && !span_i[0] && sid_lo == match_i[SB-1:0]) |=> qualify_o[0]);

  // R3
  exact_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_i && !span_i[0] && sid_lo != match_i[SB-1:0]) |=> !qualify_o[0]);

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid_i && span_i[0] && (&match_i[SB-1:0])) |=> qualify_o[0]);
endmodule

// File: tb/sid_span_filter_tb.sv
module sid_span_filter_tb_top;
  localparam int NC = 4;
  localparam int SB = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            evt_valid = 1'b0;
  logic [31:0]     evt_sid = '0;
  logic [NC*32-1:0] match = '0;
  logic [NC-1:0]   span = '0;
  logic            glob = 1'b0;
  logic [NC-1:0]   qual;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  sid_span_filter #(.NUM_CTR(NC), .SID_BITS(SB)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .evt_valid_i   (evt_valid),
    .evt_sid_i     (evt_sid),
    .match_i       (match),
    .span_i        (span),
    .global_mode_i (glob),
    .qualify_o     (qual)
  );

  task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: qualify actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] model(input logic [31:0] sid);
    logic [NC-1:0] r;
    for (int k = 0; k < NC; k++) begin
      int src = glob ? 0 : k;
      logic [SB-1:0] m  = match[src*32 +: SB];
      logic [SB-1:0] dc = span[src] ? (m ^ (m + SB'(1))) : '0;
      r[k] = (((sid[SB-1:0] ^ m) & ~dc) == '0);
    end
    return r;
  endfunction

  function automatic void set_match(input int k, input logic [31:0] v);
    match[k*32 +: 32] = v;
  endfunction

  // Entered at a falling edge; returns at the next falling edge with the result due.
  task automatic pulse(input logic [31:0] sid);
    evt_sid   = sid;
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    evt_valid = 1'b1;
    span = '1;
    match = '1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", qual, '0);
    evt_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", qual, '0);
  endtask

  task automatic t_idle;
    glob = 0; span = '1; match = '1;
    evt_valid = 1'b0;
    evt_sid = 32'h1234;
    repeat (3) @(negedge clk);
    chk("R2 no strobe", qual, '0);
    pulse(32'h1234);
    chk("R2 strobe result", qual, '1);
    @(negedge clk);
    chk("R2 drop after strobe", qual, '0);
  endtask

  task automatic t_exact;
    glob = 0; span = '0;
    for (int k = 0; k < NC; k++) set_match(k, 32'h0042);
    pulse(32'h0042);
    chk("R3 exact hit", qual, '1);
    pulse(32'h0043);
    chk("R3 exact miss lsb", qual, '0);
    pulse(32'h8042);
    chk("R3 exact miss msb", qual, model(32'h8042));
  endtask

  task automatic t_span_pair;
    glob = 0; span = '1;
    for (int k = 0; k < NC; k++) set_match(k, 32'h0042);
    pulse(32'h0042); chk("R4 span 0x42", qual, '1);
    pulse(32'h0043); chk("R4 span 0x43", qual, '1);
    pulse(32'h0040); chk("R4 span 0x40", qual, '0);
    pulse(32'h0044); chk("R4 span 0x44", qual, '0);
  endtask

  task automatic t_span_wide;
    glob = 0; span = '1;
    for (int k = 0; k < NC; k++) set_match(k, 32'h1237);
    for (int s = 32'h1228; s < 32'h1248; s++) begin
      logic [NC-1:0] e = (s >= 32'h1230 && s <= 32'h123F) ? '1 : '0;
      pulse(32'(s));
      chk("R5 span range", qual, e);
    end
  endtask

  task automatic t_bypass;
    glob = 0; span = '1;
    for (int k = 0; k < NC; k++) set_match(k, 32'hFFFF_FFFF);
    pulse(32'h0000_0000); chk("R6 bypass zero", qual, '1);
    pulse(32'hDEAD_BEEF); chk("R6 bypass any", qual, '1);
    for (int k = 0; k < NC; k++) set_match(k, 32'h0000_FFFF);
    pulse(32'h5A5A_1357); chk("R6 bypass low ones", qual, '1);
  endtask

  task automatic t_upper;
    glob = 0; span = '0;
    for (int k = 0; k < NC; k++) set_match(k, 32'h5555_0042);
    pulse(32'hABCD_0042); chk("R7 upper ignored exact", qual, '1);
    span = '1;
    pulse(32'h0001_0043); chk("R7 upper ignored span", qual, '1);
  endtask

  task automatic t_per_counter;
    glob = 0;
    set_match(0, 32'h0010); set_match(1, 32'h0011);
    set_match(2, 32'h0010); set_match(3, 32'h0020);
    span = 4'b0010;
    pulse(32'h0010); chk("R8 per counter sid 0x10", qual, 4'b0111);
    pulse(32'h0011); chk("R8 per counter sid 0x11", qual, 4'b0010);
    pulse(32'h0020); chk("R8 per counter sid 0x20", qual, model(32'h0020));
  endtask

  task automatic t_global;
    glob = 1;
    set_match(0, 32'h0042); set_match(1, 32'h0099);
    set_match(2, 32'hFFFF); set_match(3, 32'h0043);
    span = 4'b0101;
    pulse(32'h0043); chk("R9 global span hit", qual, '1);
    pulse(32'h0099); chk("R9 global others ignored", qual, '0);
    span = 4'b1110;
    pulse(32'h0043); chk("R9 global exact miss", qual, '0);
    pulse(32'h0042); chk("R9 global exact hit", qual, '1);
    glob = 0;
  endtask

  task automatic t_sample_edge;
    glob = 0; span = '0;
    for (int k = 0; k < NC; k++) set_match(k, 32'h0010);
    evt_sid = 32'h0010;
    evt_valid = 1'b1;
    @(posedge clk);
    #1;
    for (int k = 0; k < NC; k++) set_match(k, 32'h0020);
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R10 sampled at strobe edge", qual, '1);
    @(negedge clk);
    chk("R10 next cycle idle", qual, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_exact();
    t_span_pair();
    t_span_wide();
    t_bypass();
    t_upper();
    t_per_counter();
    t_global();
    t_sample_edge();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule